// File: doc/BRIEF.md
# Coarse/Fine Programmable Clock Divider

This block divides a fast clock by a programmable ratio for the feedback path of a frequency synthesizer loop. A prescaler counter runs at the fast clock and divides by 33 or by 32, depending on a modulus-control bit. Its terminal-count enable advances a single 8-bit up-counter. One shared equality comparator checks the next counter value against either twice the fine setting or the coarse setting, as chosen by a phase bit. Phase logic decides whether each match is a fine match or a coarse match. It then flips the phase, drives the modulus control and restarts the counter. An output toggle turns the merged match pulses into the divided clock.

A cycle begins in the fine phase with modulus 33. The counter takes 2·FR prescaler periods to reach 2·FR, which gives a fine match. At that point the output rises and the prescaler switches to modulus 32. The counter then keeps counting up to CR, which gives a coarse match. At that point the output falls, the counter clears and the next cycle starts. The output period is exactly 32·CR + 2·FR fast-clock cycles. New settings are sampled only at a coarse match. A setting with FR of zero, or with 2·FR not below CR, is illegal. While the held setting is illegal, the divider stays idle with its output low and raises an error flag. In that state it resamples the inputs on every cycle and starts cleanly once they become legal.

All logic runs in the fast clock domain. Every match pulse lasts one fast cycle and is qualified by the prescaler enable, so a counter that rests on a matching value can never match twice.

Top module: `cfdiv_top`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it is released, clk_o is 0 and err_o is 0. The first rising edge of clk_o comes 66·FR cycles after the settings are taken in the first cycle after reset.
- R2: In the fine phase the prescaler spans 33 fast cycles per counter step. clk_o therefore stays low for exactly 66·FR fast cycles per output period.
- R3: A fine match (counter reaches 2·FR) sets clk_o to 1 and switches the prescaler to 32 cycles per step without clearing the counter. clk_o stays high for exactly 32·(CR − 2·FR) fast cycles.
- R4: A coarse match (counter reaches CR) sets clk_o to 0, clears the counter and returns the divider to the fine phase with modulus 33.
- R5: With legal settings the output period is exactly 32·CR + 2·FR fast cycles. Examples: CR=14, FR=4 gives 456; CR=30, FR=12 gives 984; CR=36, FR=8 gives 1168; CR=255, FR=127 gives 8414.
- R6: clk_o changes only on a match pulse. There is at most one match pulse per prescaler period, and never a fine and a coarse match together.
- R7: A setting is legal only when FR ≠ 0 and 2·FR < CR, compared as unsigned numbers with 2·FR taken 9 bits wide. While the held setting is illegal, clk_o is 0, err_o is 1, and the inputs are resampled every cycle. A legal input clears err_o one cycle after it is sampled. The next fine phase then starts at once.
- R8: While the divider runs, changes on coarse_i and fine_i have no effect until the next coarse match. The cycle in progress completes with the old setting.
- R9: A setting sampled at a coarse match takes effect from the next cycle on. If it is illegal, err_o rises in the same cycle in which clk_o falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast input clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| coarse_i | input | 8 | Coarse setting CR, counter value for the coarse match |
| fine_i | input | 8 | Fine setting FR; the fine match occurs at counter value 2·FR |
| clk_o | output | 1 | Divided clock, low in the fine phase and high in the coarse phase |
| err_o | output | 1 | High while the held setting is illegal and the divider is idle |

## Verification
The coarse match and the sampling of a new setting fall in the same cycle. The counter clear, the return to modulus 33, the falling edge of clk_o and the possible move to the illegal idle state therefore all happen on one edge. The bench provokes this by staging new values during a running cycle, one set legal and one with FR of zero, so that they are taken exactly at the coarse match. It then judges every cycle against a behavioural phase-length model. It also checks that err_o rises together with the falling edge of clk_o, and that the cycle in progress still completes with the old lengths.

// File: rtl/cfdiv_pkg.sv
package cfdiv_pkg;
  typedef enum logic {
    PH_FINE   = 1'b0,
    PH_COARSE = 1'b1
  } phase_e;

  localparam int unsigned DEF_CNT_W    = 8;
  localparam int unsigned DEF_PRE_BASE = 32;
endpackage

// File: rtl/cfdiv_cfg.sv
module cfdiv_cfg #(
  parameter int unsigned CNT_W = cfdiv_pkg::DEF_CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] coarse_i,
  input  logic [CNT_W-1:0] fine_i,
  input  logic             reload_i,
  output logic [CNT_W-1:0] cr_o,
  output logic [CNT_W-1:0] fr_o,
  output logic             run_o,
  output logic             err_o
);
  logic             wait_q;
  logic [CNT_W-1:0] cr_q, fr_q;
  logic             cfg_ok, take;

  // fine target is 2*FR, compared one bit wider than the counter
  assign cfg_ok = (fr_q != '0) && ({fr_q, 1'b0} < {1'b0, cr_q});
  assign take   = wait_q || !cfg_ok || reload_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wait_q <= 1'b1;
      cr_q   <= '0;
      fr_q   <= '0;
    end else begin
      wait_q <= 1'b0;
      if (take) begin
        cr_q <= coarse_i;
        fr_q <= fine_i;
      end
    end
  end

  assign cr_o  = cr_q;
  assign fr_o  = fr_q;
  assign run_o = !wait_q && cfg_ok;
  assign err_o = !wait_q && !cfg_ok;
endmodule

// File: rtl/cfdiv_prescaler.sv
module cfdiv_prescaler #(
  parameter int unsigned PRE_BASE = cfdiv_pkg::DEF_PRE_BASE
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic mc_i,
  output logic tick_o
);
  localparam int unsigned PRE_W = $clog2(PRE_BASE + 1);

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] term;

  // modulus PRE_BASE+1 when mc_i is set, PRE_BASE otherwise
  assign term   = mc_i ? PRE_W'(PRE_BASE) : PRE_W'(PRE_BASE - 1);
  assign tick_o = run_i && (pre_q == term);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          pre_q <= '0;
    else if (!run_i)      pre_q <= '0;
    else if (pre_q == term) pre_q <= '0;
    else                  pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/cfdiv_upcnt.sv
module cfdiv_upcnt #(
  parameter int unsigned CNT_W = cfdiv_pkg::DEF_CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W:0]   nxt_o
);
  logic [CNT_W-1:0] cnt_q;

  assign nxt_o = {1'b0, cnt_q} + 1'b1;
  assign cnt_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (inc_i) cnt_q <= nxt_o[CNT_W-1:0];
  end
endmodule

// File: rtl/cfdiv_ctrl.sv
module cfdiv_ctrl
  import cfdiv_pkg::*;
#(
  parameter int unsigned CNT_W = cfdiv_pkg::DEF_CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic [CNT_W:0]   nxt_i,
  input  logic [CNT_W-1:0] cr_i,
  input  logic [CNT_W-1:0] fr_i,
  output logic             sel_o,
  output logic             mc_o,
  output logic             fine_hit_o,
  output logic             coarse_hit_o,
  output logic             out_o
);
  localparam int unsigned CMP_W = CNT_W + 1;

  phase_e           phase_q;
  logic             mc_q, out_q;
  logic [CMP_W-1:0] operand;
  logic [CMP_W-1:0] same;
  logic             eq, hit;

  assign operand = (phase_q == PH_COARSE) ? {1'b0, cr_i} : {fr_i, 1'b0};

  // shared comparator, one bit cell per position
  for (genvar i = 0; i < CMP_W; i++) begin : g_cmp
    assign same[i] = ~(operand[i] ^ nxt_i[i]);
  end
  assign eq = &same;

  // only the prescaler enable qualifies a match: one pulse per counter step
  assign hit          = tick_i && eq;
  assign fine_hit_o   = hit && (phase_q == PH_FINE);
  assign coarse_hit_o = hit && (phase_q == PH_COARSE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_FINE;
      mc_q    <= 1'b1;
      out_q   <= 1'b0;
    end else if (!run_i) begin
      phase_q <= PH_FINE;
      mc_q    <= 1'b1;
      out_q   <= 1'b0;
    end else if (fine_hit_o) begin
      phase_q <= PH_COARSE;
      mc_q    <= 1'b0;
      out_q   <= ~out_q;
    end else if (coarse_hit_o) begin
      phase_q <= PH_FINE;
      mc_q    <= 1'b1;
      out_q   <= ~out_q;
    end
  end

  assign sel_o = (phase_q == PH_COARSE);
  assign mc_o  = mc_q;
  assign out_o = out_q;
endmodule

// File: rtl/cfdiv_top.sv
module cfdiv_top #(
  parameter int unsigned CNT_W    = cfdiv_pkg::DEF_CNT_W,
  parameter int unsigned PRE_BASE = cfdiv_pkg::DEF_PRE_BASE
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] coarse_i,
  input  logic [CNT_W-1:0] fine_i,
  output logic             clk_o,
  output logic             err_o
);
  logic [CNT_W-1:0] cr_q, fr_q, up_cnt;
  logic [CNT_W:0]   up_nxt;
  logic             run, tick, sel, mc, fine_hit, coarse_hit;

  cfdiv_cfg #(.CNT_W(CNT_W)) u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .coarse_i (coarse_i),
    .fine_i   (fine_i),
    .reload_i (coarse_hit),
    .cr_o     (cr_q),
    .fr_o     (fr_q),
    .run_o    (run),
    .err_o    (err_o)
  );

  cfdiv_prescaler #(.PRE_BASE(PRE_BASE)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .mc_i   (mc),
    .tick_o (tick)
  );

  cfdiv_upcnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (!run || coarse_hit),
    .inc_i  (tick),
    .cnt_o  (up_cnt),
    .nxt_o  (up_nxt)
  );

  cfdiv_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .run_i        (run),
    .tick_i       (tick),
    .nxt_i        (up_nxt),
    .cr_i         (cr_q),
    .fr_i         (fr_q),
    .sel_o        (sel),
    .mc_o         (mc),
    .fine_hit_o   (fine_hit),
    .coarse_hit_o (coarse_hit),
    .out_o        (clk_o)
  );
endmodule

// File: rtl/cfdiv_checker.sv
module cfdiv_checker #(
  parameter int unsigned CNT_W    = cfdiv_pkg::DEF_CNT_W,
  parameter int unsigned PRE_BASE = cfdiv_pkg::DEF_PRE_BASE
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             run,
  input logic             tick,
  input logic             sel,
  input logic             mc,
  input logic             fine_hit,
  input logic             coarse_hit,
  input logic [CNT_W-1:0] up_cnt,
  input logic [CNT_W-1:0] cr_q,
  input logic [CNT_W-1:0] fr_q,
  input logic             clk_o,
  input logic             err_o
);
  localparam int unsigned GAP_W = $clog2(PRE_BASE + 2);

  logic [GAP_W-1:0] gap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     gap_q <= '0;
    else if (!run)   gap_q <= '0;
    else if (tick)   gap_q <= '0;
    else             gap_q <= gap_q + 1'b1;
  end

  AST_PRE_MODULUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick |-> (gap_q == (mc ? GAP_W'(PRE_BASE) : GAP_W'(PRE_BASE - 1)))); // R2
  AST_FINE_KEEPS_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fine_hit |=> (sel && !mc && up_cnt != '0)); // R3
  AST_FINE_RAISES_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fine_hit |=> clk_o); // R3
  AST_COARSE_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    coarse_hit |=> (up_cnt == '0 && !sel && mc && !clk_o)); // R4
  AST_OUT_ONLY_ON_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && !fine_hit && !coarse_hit) |=> $stable(clk_o)); // R6
  AST_ONE_MATCH_KIND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({fine_hit, coarse_hit})); // R6
  AST_ERR_HOLDS_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !clk_o); // R7
  AST_CFG_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && !coarse_hit) |=> ($stable(cr_q) && $stable(fr_q))); // R8
endmodule

bind cfdiv_top cfdiv_checker #(.CNT_W(CNT_W), .PRE_BASE(PRE_BASE)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .run        (run),
  .tick       (tick),
  .sel        (sel),
  .mc         (mc),
  .fine_hit   (fine_hit),
  .coarse_hit (coarse_hit),
  .up_cnt     (up_cnt),
  .cr_q       (cr_q),
  .fr_q       (fr_q),
  .clk_o      (clk_o),
  .err_o      (err_o)
);

// File: tb/cfdiv_top_test.sv
`timescale 1ns/1ps
module cfdiv_top_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] coarse_i = 8'd14;
  logic [7:0] fine_i = 8'd4;
  logic       clk_o, err_o;

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  cfdiv_top uut (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .coarse_i (coarse_i),
    .fine_i   (fine_i),
    .clk_o    (clk_o),
    .err_o    (err_o)
  );

  task automatic check(input string tag, input int act, input int exp, input string what);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic bit legal(input int cr, input int fr);
    return (fr != 0) && (2 * fr < cr);
  endfunction

  // behavioural phase-length model
  bit m_wait, m_out;
  int m_cr, m_fr, m_rem;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_wait = 1; m_out = 0; m_cr = 0; m_fr = 0; m_rem = 0;
    end else if (m_wait || !legal(m_cr, m_fr)) begin
      m_wait = 0; m_cr = coarse_i; m_fr = fine_i; m_rem = 66 * fine_i; m_out = 0;
    end else begin
      m_rem--;
      if (m_rem == 0) begin
        if (!m_out) begin
          m_out = 1; m_rem = 32 * (m_cr - 2 * m_fr);
        end else begin
          m_out = 0; m_cr = coarse_i; m_fr = fine_i; m_rem = 66 * fine_i;
        end
      end
    end
  end

  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      check("R6", clk_o, m_out, "per-cycle clk_o vs model");
      check("R7", err_o, (!m_wait && !legal(m_cr, m_fr)), "per-cycle err_o vs model");
    end
  end

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      n_chk++; n_err++;
      $display("FAIL R5 watchdog: actual=%0d expected=%0d", cyc, 150000);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  task automatic wait_level(input logic v, output int n);
    n = 0;
    while (clk_o !== v) begin
      @(negedge clk_i);
      n++;
    end
  endtask

  initial begin
    int h, l, n;
    repeat (3) @(negedge clk_i);
    check("R1", clk_o, 0, "clk_o in reset");
    check("R1", err_o, 0, "err_o in reset");
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1", clk_o, 0, "clk_o first cycle after reset");
    check("R1", err_o, 0, "err_o first cycle after reset");
    wait_level(1'b1, n);
    check("R1", n, 264, "first rise delay");
    wait_level(1'b0, h);
    check("R3", h, 192, "high time 14/4");
    wait_level(1'b1, l);
    check("R2", l, 264, "low time 14/4");
    check("R5", h + l, 456, "period 14/4");
    // stage new values at the start of a fine phase: old cycle must finish
    wait_level(1'b0, h);
    coarse_i = 8'd30; fine_i = 8'd12;
    wait_level(1'b1, l);
    check("R8", l, 264, "low time kept after mid-run change");
    wait_level(1'b0, h);
    check("R8", h, 192, "high time kept after mid-run change");
    wait_level(1'b1, l);
    check("R2", l, 792, "low time 30/12");
    wait_level(1'b0, h);
    check("R3", h, 192, "high time 30/12");
    check("R5", h + l, 984, "period 30/12");
    // illegal value staged, taken at the coarse match
    fine_i = 8'd0;
    wait_level(1'b1, l);
    wait_level(1'b0, h);
    check("R9", err_o, 1, "err_o with falling clk_o");
    repeat (100) @(negedge clk_i);
    check("R7", clk_o, 0, "clk_o held low when illegal");
    check("R7", err_o, 1, "err_o held when illegal");
    coarse_i = 8'd8; fine_i = 8'd4;
    repeat (3) @(negedge clk_i);
    check("R7", err_o, 1, "err_o at 2*FR == CR");
    coarse_i = 8'd10; fine_i = 8'd4;
    @(negedge clk_i);
    check("R7", err_o, 0, "err_o cleared after legal value");
    wait_level(1'b1, l);
    check("R7", l, 264, "restart low time 10/4");
    wait_level(1'b0, h);
    check("R3", h, 64, "high time 10/4");
    wait_level(1'b1, l);
    check("R5", h + l, 328, "period 10/4");
    coarse_i = 8'd255; fine_i = 8'd127;
    wait_level(1'b0, h);
    check("R8", h, 64, "coarse phase keeps old CR");
    wait_level(1'b1, l);
    check("R2", l, 8382, "low time 255/127");
    wait_level(1'b0, h);
    check("R3", h, 32, "high time 255/127");
    check("R5", h + l, 8414, "period 255/127");
    coarse_i = 8'd36; fine_i = 8'd8;
    wait_level(1'b1, l);
    wait_level(1'b0, h);
    wait_level(1'b1, l);
    wait_level(1'b0, h);
    check("R4", h, 640, "high time 36/8");
    wait_level(1'b1, l);
    check("R5", h + l, 1168, "period 36/8");
    repeat (5) @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    check("R1", clk_o, 0, "clk_o after mid-run reset");
    check("R1", err_o, 0, "err_o after mid-run reset");
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule